// File: doc/BRIEF.md
# Masked Vector Qword Permute Unit

This unit rearranges the 64-bit elements of a wide vector. The vector is either half length (four elements, 256 bits at the default width) or full length (eight elements, 512 bits). There are two ways to choose which source element lands in each result position. In immediate mode an 8-bit control byte holds four 2-bit selectors. In index mode every result element carries its own selector in the low bits of a parallel 64-bit index vector.

Before selection, the low source element can be replicated into every lane to model a broadcast load. After selection, a per-element write mask decides each result element. The element is either written with the permuted value or replaced. The replacement is the previous destination element when merging, or zero when zeroing. Elements beyond the active length always read as zero.

Encodings that are not allowed are detected from the mode controls. Such an operation produces no result and raises an invalid-operation flag instead. Each accepted strobe yields one registered result one clock later.

Top module: `qperm_unit`

## Requirements
- R1: In immediate mode, result element k (k = 0..3) is source element `imm[2k+1:2k]`, so the byte 8'hE4 is the identity and 8'h1B reverses the four elements.
- R2: At full length in immediate mode, result element 4+k uses the same field `imm[2k+1:2k]` but selects source element 4 + that value. An upper result element never takes a lower source element.
- R3: In index mode at full length, result element j is source element `idx[64j+2:64j]`. All other bits of each index element have no effect.
- R4: In index mode at half length, result element j is source element `idx[64j+1:64j]`. Bit 2 and every higher bit of each index element have no effect.
- R5: When `ext_enc`, `bcst_en` and `src_mem` are all 1, source element 0 replaces every source lane before selection. If `src_mem` is 0, `bcst_en` has no effect.
- R6: With masking on (`ext_enc`=1 and `mask_en`=1), a clear bit `mask[j]` makes result element j equal to `old_dst` element j when `zero_mode`=0, or zero when `zero_mode`=1. At half length only `mask[3:0]` is consulted.
- R7: At half length (`vlen_sel`=2'b01), `out_data[511:256]` is zero whatever `old_dst`, the mask or the selectors hold.
- R8: Selectors are not checked for uniqueness: several result elements may copy the same source element.
- R9: `out_invalid` is 1 and `out_data` is all zero when any of these holds: `vlen_sel` is 2'b00 or 2'b11; `ext_enc`=0 with `vlen_sel` other than 2'b01; `ext_enc`=0 with `idx_mode`=1; `idx_mode`=0 with `reg_spec` other than 4'b1111. Index mode ignores `reg_spec`.
- R10: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid`=1, and it carries that operation's result. Reset clears `out_valid`, `out_invalid` and `out_data`.
- R11: With `ext_enc`=0, `mask_en`, `zero_mode`, `mask` and `bcst_en` have no effect, and every lane below the active length is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| vlen_sel | input | 2 | Length: 00 narrow (illegal), 01 half, 10 full, 11 reserved (illegal) |
| ext_enc | input | 1 | 1: extended encoding (mask and broadcast allowed); 0: plain encoding |
| idx_mode | input | 1 | 0: immediate selectors; 1: index-vector selectors |
| reg_spec | input | 4 | Extra register specifier; must be 4'b1111 in immediate mode |
| imm | input | 8 | Immediate selector byte |
| mask_en | input | 1 | Enable the per-element write mask |
| zero_mode | input | 1 | 1: zero masked-off elements; 0: merge with old_dst |
| mask | input | 8 | Per-element write mask |
| bcst_en | input | 1 | Broadcast request |
| src_mem | input | 1 | Source operand comes from memory |
| src | input | 512 | Source vector |
| idx | input | 512 | Index vector |
| old_dst | input | 512 | Previous destination contents |
| out_valid | output | 1 | Result valid |
| out_invalid | output | 1 | Operation rejected as an illegal encoding |
| out_data | output | 512 | Registered result |

## Verification
The bench targets the full-length immediate case. A design that let upper result elements reach the lower source half would return lower data in elements 4 to 7. Index vectors in the bench carry set bits above the selector field. A unit that used bit 2 at half length, or bit 3 at full length, would pick wrong or out-of-range elements. The bench drives mask bytes with upper bits set at half length, broadcasts with and without the memory flag, and plain encodings carrying mask controls. A design that leaked upper mask bits, ignored the memory qualifier, or applied masking to a plain encoding would show merged or zeroed lanes where written ones belong. Each illegal encoding is sent once, next to a legal index-mode operation with a bad register specifier, so the bench catches both a missed fault and a false fault.

// File: rtl/qperm_pkg.sv
package qperm_pkg;
   typedef enum logic [1:0] {
      VL_NARROW = 2'b00,
      VL_HALF   = 2'b01,
      VL_FULL   = 2'b10,
      VL_RSVD   = 2'b11
   } vlen_e;

   localparam logic [3:0] SPEC_UNUSED = 4'b1111;
endpackage

// File: rtl/qperm_src_prep.sv
module qperm_src_prep #(
   parameter int ELEM_W = 64,
   parameter int LANES  = 8
) (
   input  logic [ELEM_W*LANES-1:0] src_vec,
   input  logic                    bcst,
   output logic [ELEM_W*LANES-1:0] src_eff
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      if (k == 0) begin : g_base
         assign src_eff[0 +: ELEM_W] = src_vec[0 +: ELEM_W];
      end else begin : g_rep
         assign src_eff[k*ELEM_W +: ELEM_W] =
            bcst ? src_vec[0 +: ELEM_W] : src_vec[k*ELEM_W +: ELEM_W];
      end
   end
endmodule

// File: rtl/qperm_xbar.sv
module qperm_xbar #(
   parameter int ELEM_W = 64,
   parameter int LANES  = 8,
   parameter int IMM_W  = 8
) (
   input  logic [ELEM_W*LANES-1:0] src_vec,
   input  logic [ELEM_W*LANES-1:0] idx_vec,
   input  logic [IMM_W-1:0]        imm,
   input  logic                    idx_mode,
   input  logic                    full_len,
   output logic [ELEM_W*LANES-1:0] perm_vec
);
   localparam int HALF   = LANES / 2;
   localparam int SEL_W  = $clog2(LANES);
   localparam int HSEL_W = $clog2(HALF);

   logic [ELEM_W-1:0] lane_src [LANES];
   logic              unused_idx_bits;

   assign unused_idx_bits = ^idx_vec;

   for (genvar k = 0; k < LANES; k++) begin : g_unpack
      assign lane_src[k] = src_vec[k*ELEM_W +: ELEM_W];
   end

   for (genvar j = 0; j < LANES; j++) begin : g_out
      localparam int   LOCAL = j % HALF;
      localparam logic UPPER = (j >= HALF);
      logic [SEL_W-1:0] sel;

      always_comb begin
         if (!idx_mode) begin
            sel = {UPPER, imm[LOCAL*HSEL_W +: HSEL_W]};
         end else if (full_len) begin
            sel = idx_vec[j*ELEM_W +: SEL_W];
         end else begin
            sel = {1'b0, idx_vec[j*ELEM_W +: HSEL_W]};
         end
      end

      assign perm_vec[j*ELEM_W +: ELEM_W] = lane_src[sel];
   end
endmodule

// File: rtl/qperm_mask.sv
module qperm_mask #(
   parameter int ELEM_W = 64,
   parameter int LANES  = 8
) (
   input  logic [ELEM_W*LANES-1:0] perm_vec,
   input  logic [ELEM_W*LANES-1:0] old_vec,
   input  logic [LANES-1:0]        mask,
   input  logic                    mask_on,
   input  logic                    zero_mode,
   input  logic                    full_len,
   output logic [ELEM_W*LANES-1:0] dst_vec
);
   localparam int HALF = LANES / 2;

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      localparam logic UPPER = (j >= HALF);
      logic [ELEM_W-1:0] lane_val;

      always_comb begin
         if (UPPER && !full_len) begin
            lane_val = '0;
         end else if (!mask_on || mask[j]) begin
            lane_val = perm_vec[j*ELEM_W +: ELEM_W];
         end else if (zero_mode) begin
            lane_val = '0;
         end else begin
            lane_val = old_vec[j*ELEM_W +: ELEM_W];
         end
      end

      assign dst_vec[j*ELEM_W +: ELEM_W] = lane_val;
   end
endmodule

// File: rtl/qperm_fault.sv
module qperm_fault
   import qperm_pkg::*;
(
   input  logic [1:0] vlen_sel,
   input  logic       ext_enc,
   input  logic       idx_mode,
   input  logic [3:0] reg_spec,
   output logic       fault
);
   logic bad_len;
   logic bad_plain;
   logic bad_spec;

   always_comb begin
      unique case (vlen_e'(vlen_sel))
         VL_HALF, VL_FULL: bad_len = 1'b0;
         default:          bad_len = 1'b1;
      endcase
      bad_plain = !ext_enc && ((vlen_e'(vlen_sel) != VL_HALF) || idx_mode);
      bad_spec  = !idx_mode && (reg_spec != SPEC_UNUSED);
      fault     = bad_len || bad_plain || bad_spec;
   end
endmodule

// File: rtl/qperm_unit.sv
module qperm_unit
   import qperm_pkg::*;
#(
   parameter int ELEM_W = 64,
   parameter int LANES  = 8,
   parameter int IMM_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [1:0]              vlen_sel,
   input  logic                    ext_enc,
   input  logic                    idx_mode,
   input  logic [3:0]              reg_spec,
   input  logic [IMM_W-1:0]        imm,
   input  logic                    mask_en,
   input  logic                    zero_mode,
   input  logic [LANES-1:0]        mask,
   input  logic                    bcst_en,
   input  logic                    src_mem,
   input  logic [ELEM_W*LANES-1:0] src,
   input  logic [ELEM_W*LANES-1:0] idx,
   input  logic [ELEM_W*LANES-1:0] old_dst,
   output logic                    out_valid,
   output logic                    out_invalid,
   output logic [ELEM_W*LANES-1:0] out_data
);
   localparam int HALF   = LANES / 2;
   localparam int HSEL_W = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int VEC_W  = ELEM_W * LANES;

   if (LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 4");
   end
   if (IMM_W != HALF * HSEL_W) begin : g_bad_imm
      $error("IMM_W must hold one selector per half-vector lane");
   end
   if (ELEM_W < $clog2(LANES)) begin : g_bad_elem
      $error("ELEM_W too narrow to hold an index");
   end

   logic             full_len;
   logic             mask_on;
   logic             bcst;
   logic             fault;
   logic [VEC_W-1:0] src_eff;
   logic [VEC_W-1:0] perm_vec;
   logic [VEC_W-1:0] dst_vec;

   assign full_len = (vlen_e'(vlen_sel) == VL_FULL);
   assign mask_on  = ext_enc && mask_en;
   assign bcst     = ext_enc && bcst_en && src_mem;

   qperm_src_prep #(.ELEM_W(ELEM_W), .LANES(LANES)) i_src_prep (
      .src_vec (src),
      .bcst    (bcst),
      .src_eff (src_eff)
   );

   qperm_xbar #(.ELEM_W(ELEM_W), .LANES(LANES), .IMM_W(IMM_W)) i_xbar (
      .src_vec  (src_eff),
      .idx_vec  (idx),
      .imm      (imm),
      .idx_mode (idx_mode),
      .full_len (full_len),
      .perm_vec (perm_vec)
   );

   qperm_mask #(.ELEM_W(ELEM_W), .LANES(LANES)) i_mask (
      .perm_vec  (perm_vec),
      .old_vec   (old_dst),
      .mask      (mask),
      .mask_on   (mask_on),
      .zero_mode (zero_mode),
      .full_len  (full_len),
      .dst_vec   (dst_vec)
   );

   qperm_fault i_fault (
      .vlen_sel (vlen_sel),
      .ext_enc  (ext_enc),
      .idx_mode (idx_mode),
      .reg_spec (reg_spec),
      .fault    (fault)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_invalid <= 1'b0;
         out_data    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_invalid <= fault;
            out_data    <= fault ? '0 : dst_vec;
         end
      end
   end
endmodule

// File: rtl/qperm_chk.sv
module qperm_chk
   import qperm_pkg::*;
#(
   parameter int ELEM_W = 64,
   parameter int LANES  = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic [1:0]              vlen_sel,
   input logic                    ext_enc,
   input logic                    idx_mode,
   input logic [3:0]              reg_spec,
   input logic                    mask_en,
   input logic                    zero_mode,
   input logic [LANES-1:0]        mask,
   input logic                    out_valid,
   input logic                    out_invalid,
   input logic [ELEM_W*LANES-1:0] out_data
);
   localparam int VEC_W  = ELEM_W * LANES;
   localparam int HALF_W = VEC_W / 2;

   AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                          // R10
   AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                        // R10
   AST_FAULT_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_invalid) |-> (out_data == '0));                 // R9
   AST_BAD_LEN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (vlen_sel == VL_NARROW || vlen_sel == VL_RSVD)) |=> out_invalid); // R9
   AST_IMM_SPEC_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !idx_mode && reg_spec != SPEC_UNUSED) |=> out_invalid); // R9
   AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && vlen_sel == VL_HALF) |=> (out_data[VEC_W-1:HALF_W] == '0)); // R7
   AST_ALL_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ext_enc && mask_en && zero_mode && mask == '0) |=> (out_data == '0)); // R6
endmodule

bind qperm_unit qperm_chk #(.ELEM_W(ELEM_W), .LANES(LANES)) i_qperm_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .vlen_sel    (vlen_sel),
   .ext_enc     (ext_enc),
   .idx_mode    (idx_mode),
   .reg_spec    (reg_spec),
   .mask_en     (mask_en),
   .zero_mode   (zero_mode),
   .mask        (mask),
   .out_valid   (out_valid),
   .out_invalid (out_invalid),
   .out_data    (out_data)
);

// File: tb/test_qperm_unit.sv
module test_qperm_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   vlen_sel = 2'b01;
   logic         ext_enc = 1'b1;
   logic         idx_mode = 1'b0;
   logic [3:0]   reg_spec = 4'hF;
   logic [7:0]   imm = 8'h00;
   logic         mask_en = 1'b0;
   logic         zero_mode = 1'b0;
   logic [7:0]   mask = 8'h00;
   logic         bcst_en = 1'b0;
   logic         src_mem = 1'b0;
   logic [511:0] src = '0;
   logic [511:0] idx = '0;
   logic [511:0] old_dst = '0;
   logic         out_valid;
   logic         out_invalid;
   logic [511:0] out_data;

   int n_checks = 0;
   int n_fails  = 0;
   logic [512:0] q_exp[$];
   string        q_tag[$];

   always #4 clk = ~clk;

   qperm_unit i_qperm_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vlen_sel(vlen_sel),
      .ext_enc(ext_enc), .idx_mode(idx_mode), .reg_spec(reg_spec), .imm(imm),
      .mask_en(mask_en), .zero_mode(zero_mode), .mask(mask), .bcst_en(bcst_en),
      .src_mem(src_mem), .src(src), .idx(idx), .old_dst(old_dst),
      .out_valid(out_valid), .out_invalid(out_invalid), .out_data(out_data)
   );

   task automatic check(input string tag, input logic [512:0] act, input logic [512:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [512:0] model();
      logic [63:0]  s [8];
      logic [511:0] res;
      int           nl;
      int           pick;
      logic [63:0]  v;
      if ((vlen_sel != 2'b01 && vlen_sel != 2'b10) || (!ext_enc && vlen_sel != 2'b01) ||
          (!ext_enc && idx_mode) || (!idx_mode && reg_spec != 4'hF))
         return {1'b1, 512'b0};
      nl  = (vlen_sel == 2'b10) ? 8 : 4;
      res = '0;
      for (int k = 0; k < 8; k++)
         s[k] = (ext_enc && bcst_en && src_mem) ? src[63:0] : src[k*64 +: 64];
      for (int j = 0; j < nl; j++) begin
         if (idx_mode) pick = (nl == 8) ? int'(idx[j*64 +: 3]) : int'(idx[j*64 +: 2]);
         else          pick = (j / 4) * 4 + int'(imm[(j % 4)*2 +: 2]);
         v = s[pick];
         if (ext_enc && mask_en && !mask[j]) v = zero_mode ? 64'h0 : old_dst[j*64 +: 64];
         res[j*64 +: 64] = v;
      end
      return {1'b0, res};
   endfunction

   // driver: issue the currently set operation and queue its expected result
   task automatic fire(input string tag);
      in_valid = 1'b1;
      q_exp.push_back(model());
      q_tag.push_back(tag);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic set_basic(input logic [1:0] vl, input logic im, input logic [7:0] iv);
      vlen_sel = vl; idx_mode = im; imm = iv; ext_enc = 1'b1; reg_spec = 4'hF;
      mask_en = 1'b0; zero_mode = 1'b0; mask = 8'h00; bcst_en = 1'b0; src_mem = 1'b0;
   endtask

   function automatic logic [511:0] pattern(input logic [15:0] tagv);
      logic [511:0] p;
      for (int k = 0; k < 8; k++) p[k*64 +: 64] = {tagv, 40'hC0FFEE0000, 8'(k)};
      return p;
   endfunction

   // monitor: compare each produced result with the head of the queue
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q_exp.size() == 0) begin
            check("R10 unexpected out_valid", 513'd1, 513'd0);
         end else begin
            logic [512:0] e;
            string        t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check(t, {out_invalid, out_data}, e);
         end
      end
   end

   initial begin
      #(8 * 200000);
      n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

   initial begin
      src = pattern(16'hA5A5);
      old_dst = pattern(16'h0D0D);
      repeat (3) @(negedge clk);
      check("R10 reset out_valid", {512'b0, out_valid}, 513'd0);
      check("R10 reset data", {out_invalid, out_data}, 513'd0);
      rst_n = 1'b1;
      @(negedge clk);

      set_basic(2'b01, 1'b0, 8'hE4); fire("R1 identity");
      set_basic(2'b01, 1'b0, 8'h1B); fire("R1 reverse");
      set_basic(2'b01, 1'b0, 8'hAA); fire("R8 duplicate element 2");
      set_basic(2'b10, 1'b0, 8'h4E); fire("R2 full-length imm halves");
      set_basic(2'b10, 1'b0, 8'h00); fire("R2 upper stays upper");
      set_basic(2'b10, 1'b1, 8'h00);
      for (int j = 0; j < 8; j++) idx[j*64 +: 64] = {56'hFFFF_FFFF_FFFF_F0, 8'(8'hF8 | 8'(7 - j))};
      fire("R3 full index high bits ignored");
      set_basic(2'b01, 1'b1, 8'h00);
      for (int j = 0; j < 8; j++) idx[j*64 +: 64] = {60'hABCDEF0123456F, 4'(4'hC | 4'(j ^ 1))};
      fire("R4 half index bit2 ignored");
      set_basic(2'b10, 1'b1, 8'h00);
      for (int j = 0; j < 8; j++) idx[j*64 +: 64] = 64'(3);
      fire("R8 all take element 3");
      set_basic(2'b10, 1'b0, 8'h1B); bcst_en = 1'b1; src_mem = 1'b1; fire("R5 broadcast");
      set_basic(2'b10, 1'b0, 8'h1B); bcst_en = 1'b1; src_mem = 1'b0; fire("R5 no memory no broadcast");
      set_basic(2'b10, 1'b0, 8'hE4); mask_en = 1'b1; mask = 8'h5A; fire("R6 merge");
      set_basic(2'b10, 1'b0, 8'hE4); mask_en = 1'b1; mask = 8'h5A; zero_mode = 1'b1; fire("R6 zero");
      set_basic(2'b01, 1'b0, 8'h1B); mask_en = 1'b1; mask = 8'hF0; fire("R6 half uses low mask bits");
      set_basic(2'b01, 1'b0, 8'hE4); fire("R7 upper half zero");
      set_basic(2'b00, 1'b0, 8'hE4); fire("R9 narrow length");
      set_basic(2'b11, 1'b0, 8'hE4); fire("R9 reserved length");
      set_basic(2'b10, 1'b0, 8'hE4); ext_enc = 1'b0; fire("R9 plain full length");
      set_basic(2'b01, 1'b1, 8'hE4); ext_enc = 1'b0; fire("R9 plain index mode");
      set_basic(2'b10, 1'b0, 8'hE4); reg_spec = 4'b0111; fire("R9 imm bad specifier");
      set_basic(2'b10, 1'b1, 8'hE4); reg_spec = 4'b0000; fire("R9 index ignores specifier");
      set_basic(2'b01, 1'b0, 8'h1B); ext_enc = 1'b0; mask_en = 1'b1; zero_mode = 1'b1;
      mask = 8'h00; bcst_en = 1'b1; src_mem = 1'b1; fire("R11 plain ignores mask and broadcast");

      for (int n = 0; n < 400; n++) begin
         int r;
         r = int'($urandom_range(0, 19));
         vlen_sel  = (r == 0) ? 2'b00 : (r == 1) ? 2'b11 : (r < 10) ? 2'b01 : 2'b10;
         ext_enc   = ($urandom_range(0, 9) != 0);
         idx_mode  = 1'($urandom);
         reg_spec  = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'hF;
         imm       = 8'($urandom);
         mask_en   = 1'($urandom);
         zero_mode = 1'($urandom);
         mask      = 8'($urandom);
         bcst_en   = 1'($urandom);
         src_mem   = 1'($urandom);
         for (int k = 0; k < 16; k++) begin
            src[k*32 +: 32]     = $urandom;
            idx[k*32 +: 32]     = $urandom;
            old_dst[k*32 +: 32] = $urandom;
         end
         fire("R10 random mix");
      end

      repeat (4) @(negedge clk);
      check("R10 all results delivered", 513'(q_exp.size()), 513'd0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end
endmodule